// File: doc/BRIEF.md
# Multi-Timer Bank with Watchdog

The block holds six down-counting timers of unequal size behind a small word-addressed register port. Two long timers have wide counters driven by short prescalers. Three short timers have narrow counters driven by wider prescalers. The last timer is a watchdog. Each timer has its own prescaler, which divides the clock by its reload value plus one. Its counter steps down once per prescaler terminal count. On reaching zero the counter either stops (one-shot) or reloads and keeps going (periodic). In either mode it sets a sticky pending flag.

Every timer presents an interrupt request together with a three-bit priority level. Software reads the pending flags from one shared register and clears them by writing ones. Arbitration between timers and vector delivery happen elsewhere. The watchdog works like the other timers, but its expiry also sets a latched system-fail output. Software keeps that output low by writing the retrigger register before the count runs out.

Top module: `tmr_bank`

## Requirements
- R1: Reset clears every control, reload, prescaler and count register. It also clears all pending flags and the fail latch, so `irq_req` and `sys_fail` are low and every address reads zero.
- R2: Writes to a timer's registers keep only the implemented bits, and reads return them. Word address 4*t+0 is control, +1 is reload, +2 is prescaler reload and +3 is the current count (read-only). The long timers (0, 1) keep 24 reload bits and 5 prescaler bits. The short timers (2 to 4) keep 8 and 8. The watchdog (5) keeps 16 and 8. In control, bit 0 is run, bit 1 periodic, bit 2 interrupt enable and bits 6:4 the level; all other bits read as zero.
- R3: A control write that changes run from 0 to 1 loads the count from reload and the prescaler from its reload. While run is 1 the count drops by one every (prescaler reload + 1) cycles. Clearing run freezes the count.
- R4: In one-shot mode the pending flag sets N*(P+1) cycles after the load (N = reload, P = prescaler reload). The count then stays at zero.
- R5: In periodic mode the count reloads on reaching zero and the pending flag sets again every N*(P+1) cycles.
- R6: Pending flags sit in bits 5:0 of word 24, bit t for timer t. Writing 1 to a bit clears it and writing 0 has no effect. When an expiry and a clear land in the same cycle, the flag stays set.
- R7: `irq_req[t]` is high while timer t's pending flag and interrupt enable are both 1 and its level is non-zero. `irq_level[3t+2:3t]` carries the level. A level of 0 keeps the request low.
- R8: A write of any value to word 25 reloads the watchdog count and prescaler. Watchdog expiry sets `sys_fail`.
- R9: `sys_fail` stays high until a write to word 26 with bit 0 set, or a reset. A write to word 26 with bit 0 clear leaves it set. Word 26 reads back the latch in bit 0.
- R10: A timer whose reload is 0 never counts and never sets its pending flag, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_req | output | 6 | Per-timer interrupt request |
| irq_level | output | 18 | Three-bit level per timer, timer t at bits 3t+2:3t |
| sys_fail | output | 1 | Latched watchdog failure |

## Verification
Two cases are hard to reach from the ports. The first is a pending-clear write that commits on exactly the edge where a periodic timer expires. The second is a watchdog retrigger that lands just before the terminal count. The bench runs a periodic timer with no prescaling and a period of two cycles, so the expiry edges can be counted exactly. It issues one clear on a quiet edge and a second clear on the expiry edge. For the watchdog, the retrigger is issued two steps before the count would have expired. The bench then confirms that the fail output rises exactly one full interval after the retrigger, and not before.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // field select inside a timer's four-word register group
   localparam logic [1:0] FLD_CTRL   = 2'd0;
   localparam logic [1:0] FLD_RELOAD = 2'd1;
   localparam logic [1:0] FLD_PRE    = 2'd2;
   localparam logic [1:0] FLD_COUNT  = 2'd3;

   // control word bit positions
   localparam int CTL_RUN = 0;
   localparam int CTL_PER = 1;
   localparam int CTL_IE  = 2;
   localparam int CTL_LVL = 4;
   localparam int LVL_W   = 3;

   typedef struct packed {
      logic [LVL_W-1:0] level;
      logic             ie;
      logic             per;
      logic             run;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          en,
   input  logic [PW-1:0] div_rl,
   output logic          tc
);

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (load)
         pre_q <= div_rl;
      else if (en)
         pre_q <= (pre_q == '0) ? div_rl : pre_q - 1'b1;
   end

   assign tc = en && !load && (pre_q == '0);

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          periodic,
   input  logic [CW-1:0] rl,
   output logic [CW-1:0] cnt,
   output logic          nonzero,
   output logic          expire
);

   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= rl;
      else if (step)
         cnt <= (cnt == ONE && periodic) ? rl : cnt - 1'b1;
   end

   assign nonzero = (cnt != '0);
   assign expire  = step && (cnt == ONE);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int DW = 32,
   parameter int CW = 24,
   parameter int PW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctrl,
   input  logic                wr_reload,
   input  logic                wr_pre,
   input  logic                kick,
   input  logic                clr_pend,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rd_ctrl,
   output logic [DW-1:0]       rd_reload,
   output logic [DW-1:0]       rd_pre,
   output logic [DW-1:0]       rd_count,
   output logic                pend,
   output logic                irq,
   output logic [LVL_W-1:0]    level,
   output logic                expire
);

   if (CW > DW || PW > DW || CW < 1 || PW < 1) begin : g_bad_width
      $error("tmr_channel: counter or prescaler width out of range");
   end

   tmr_ctrl_t     ctrl_q;
   logic [CW-1:0] reload_q;
   logic [PW-1:0] pre_rl_q;
   logic [CW-1:0] cnt;
   logic          nonzero;
   logic          load;
   logic          en;
   logic          tc;
   logic          unused_wdata_ok;

   assign unused_wdata_ok = ^wdata;

   // a control write only restarts the timer on a 0 -> 1 run transition
   assign load = (wr_ctrl && wdata[CTL_RUN] && !ctrl_q.run) || kick;
   assign en   = ctrl_q.run && nonzero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         pre_rl_q <= '0;
         pend     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run   <= wdata[CTL_RUN];
            ctrl_q.per   <= wdata[CTL_PER];
            ctrl_q.ie    <= wdata[CTL_IE];
            ctrl_q.level <= wdata[CTL_LVL +: LVL_W];
         end
         if (wr_reload) reload_q <= wdata[CW-1:0];
         if (wr_pre)    pre_rl_q <= wdata[PW-1:0];
         if (expire)
            pend <= 1'b1;
         else if (clr_pend)
            pend <= 1'b0;
      end
   end

   tmr_prescaler #(.PW(PW)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .en     (en),
      .div_rl (pre_rl_q),
      .tc     (tc)
   );

   tmr_downcount #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (tc),
      .periodic (ctrl_q.per),
      .rl       (reload_q),
      .cnt      (cnt),
      .nonzero  (nonzero),
      .expire   (expire)
   );

   assign level     = ctrl_q.level;
   assign irq       = pend && ctrl_q.ie && (ctrl_q.level != '0);
   assign rd_ctrl   = DW'({ctrl_q.level, 1'b0, ctrl_q.ie, ctrl_q.per, ctrl_q.run});
   assign rd_reload = DW'(reload_q);
   assign rd_pre    = DW'(pre_rl_q);
   assign rd_count  = DW'(cnt);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 5,
   parameter int N_LONG   = 2,
   parameter int N_SHORT  = 3,
   parameter int LONG_W   = 24,
   parameter int LONG_PW  = 5,
   parameter int SHORT_W  = 8,
   parameter int SHORT_PW = 8,
   parameter int WD_W     = 16,
   parameter int WD_PW    = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_we,
   input  logic [AW-1:0]                      bus_addr,
   input  logic [DW-1:0]                      bus_wdata,
   output logic [DW-1:0]                      bus_rdata,
   output logic [N_LONG+N_SHORT:0]            irq_req,
   output logic [(N_LONG+N_SHORT+1)*LVL_W-1:0] irq_level,
   output logic                               sys_fail
);

   localparam int NUM_TMR = N_LONG + N_SHORT + 1;
   localparam int WD_IDX  = NUM_TMR - 1;
   localparam logic [AW-1:0] PEND_A = AW'(NUM_TMR * 4);
   localparam logic [AW-1:0] KICK_A = AW'(NUM_TMR * 4 + 1);
   localparam logic [AW-1:0] FAIL_A = AW'(NUM_TMR * 4 + 2);

   if (NUM_TMR * 4 + 3 > (1 << AW)) begin : g_bad_aw
      $error("tmr_bank: address width too small for timer count");
   end
   if (NUM_TMR > DW) begin : g_bad_dw
      $error("tmr_bank: data width narrower than pending vector");
   end
   if (N_LONG < 0 || N_SHORT < 0) begin : g_bad_cnt
      $error("tmr_bank: negative timer count");
   end

   logic [DW-1:0]      rd_ctrl   [NUM_TMR];
   logic [DW-1:0]      rd_reload [NUM_TMR];
   logic [DW-1:0]      rd_pre    [NUM_TMR];
   logic [DW-1:0]      rd_count  [NUM_TMR];
   logic [NUM_TMR-1:0] pend_vec;
   logic [NUM_TMR-1:0] exp_vec;
   logic               wd_expire;
   logic               fail_q;
   logic               kick_wr;
   logic               pend_wr;
   logic               fail_clr;

   assign kick_wr  = bus_we && (bus_addr == KICK_A);
   assign pend_wr  = bus_we && (bus_addr == PEND_A);
   assign fail_clr = bus_we && (bus_addr == FAIL_A) && bus_wdata[0];

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      localparam int CW = (i < N_LONG) ? LONG_W :
                          (i < N_LONG + N_SHORT) ? SHORT_W : WD_W;
      localparam int PW = (i < N_LONG) ? LONG_PW :
                          (i < N_LONG + N_SHORT) ? SHORT_PW : WD_PW;
      localparam logic [AW-3:0] IDX = (AW-2)'(i);

      logic grp_wr;
      assign grp_wr = bus_we && (bus_addr[AW-1:2] == IDX);

      tmr_channel #(.DW(DW), .CW(CW), .PW(PW)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_ctrl   (grp_wr && bus_addr[1:0] == FLD_CTRL),
         .wr_reload (grp_wr && bus_addr[1:0] == FLD_RELOAD),
         .wr_pre    (grp_wr && bus_addr[1:0] == FLD_PRE),
         .kick      (kick_wr && (i == WD_IDX)),
         .clr_pend  (pend_wr && bus_wdata[i]),
         .wdata     (bus_wdata),
         .rd_ctrl   (rd_ctrl[i]),
         .rd_reload (rd_reload[i]),
         .rd_pre    (rd_pre[i]),
         .rd_count  (rd_count[i]),
         .pend      (pend_vec[i]),
         .irq       (irq_req[i]),
         .level     (irq_level[i*LVL_W +: LVL_W]),
         .expire    (exp_vec[i])
      );
   end

   assign wd_expire = exp_vec[WD_IDX];

   logic unused_exp_ok;
   assign unused_exp_ok = ^exp_vec;

   // expiry beats a same-cycle clear so a failure is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fail_q <= 1'b0;
      else if (wd_expire)
         fail_q <= 1'b1;
      else if (fail_clr)
         fail_q <= 1'b0;
   end

   assign sys_fail = fail_q;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (bus_addr[AW-1:2] == (AW-2)'(i)) begin
            case (bus_addr[1:0])
               FLD_CTRL:   bus_rdata = rd_ctrl[i];
               FLD_RELOAD: bus_rdata = rd_reload[i];
               FLD_PRE:    bus_rdata = rd_pre[i];
               default:    bus_rdata = rd_count[i];
            endcase
         end
      end
      if (bus_addr == PEND_A) bus_rdata = DW'(pend_vec);
      if (bus_addr == FAIL_A) bus_rdata = DW'(fail_q);
   end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
   parameter int NUM_TMR = 6,
   parameter int AW      = 5,
   parameter int DW      = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_we,
   input logic [AW-1:0]        bus_addr,
   input logic [DW-1:0]        bus_wdata,
   input logic [NUM_TMR-1:0]   irq_req,
   input logic [NUM_TMR*3-1:0] irq_level,
   input logic                 sys_fail,
   input logic [NUM_TMR-1:0]   pend,
   input logic                 wd_exp
);

   localparam logic [AW-1:0] PEND_A = AW'(NUM_TMR * 4);
   localparam logic [AW-1:0] KICK_A = AW'(NUM_TMR * 4 + 1);
   localparam logic [AW-1:0] FAIL_A = AW'(NUM_TMR * 4 + 2);

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_t
      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) pend[i] && !(bus_we && bus_addr == PEND_A && bus_wdata[i]) |=> pend[i]); // R6
      AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) irq_req[i] |-> pend[i] && (irq_level[i*3 +: 3] != 3'd0)); // R7
   end

   AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) sys_fail && !(bus_we && bus_addr == FAIL_A && bus_wdata[0]) |=> sys_fail); // R9
   AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_fail) |-> $past(wd_exp)); // R8
   AST_KICK_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == KICK_A && !sys_fail) |=> !sys_fail); // R8

endmodule

bind tmr_bank tmr_bank_chk #(
   .NUM_TMR (N_LONG + N_SHORT + 1),
   .AW      (AW),
   .DW      (DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_req   (irq_req),
   .irq_level (irq_level),
   .sys_fail  (sys_fail),
   .pend      (pend_vec),
   .wd_exp    (wd_expire)
);

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;

   localparam int PEND_A = 24;
   localparam int KICK_A = 25;
   localparam int FAIL_A = 26;
   localparam int NV     = 8;
   // {address, write data, expected read-back}
   localparam logic [68:0] VEC [NV] = '{
      {5'd1,  32'hFFFF_FFFF, 32'h00FF_FFFF},
      {5'd2,  32'hFFFF_FFFF, 32'h0000_001F},
      {5'd6,  32'h0000_0012, 32'h0000_0012},
      {5'd9,  32'h0000_01FF, 32'h0000_00FF},
      {5'd10, 32'h0000_03FF, 32'h0000_00FF},
      {5'd17, 32'h0000_ABCD, 32'h0000_00CD},
      {5'd21, 32'h0001_2345, 32'h0000_2345},
      {5'd12, 32'hFFFF_FF7E, 32'h0000_0076}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_we;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [5:0]  irq_req;
   logic [17:0] irq_level;
   logic        sys_fail;

   int checks = 0;
   int errors = 0;
   logic [31:0] rv;

   always #4 clk = ~clk;

   tmr_bank u_tmr_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_req   (irq_req),
      .irq_level (irq_level),
      .sys_fail  (sys_fail)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_we    = 1'b1;
      bus_addr  = 5'(a);
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 5'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #160000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 27; a++) begin
         rd(a, rv);
         chk("R1 reset read", rv, 32'h0);
      end
      chk("R1 irq low", 32'(irq_req), 32'h0);
      chk("R1 fail low", 32'(sys_fail), 32'h0);

      // R2 table of writes and masked read-back
      for (int v = 0; v < NV; v++) begin
         wr(int'(VEC[v][68:64]), VEC[v][63:32]);
         rd(int'(VEC[v][68:64]), rv);
         chk("R2 readback", rv, VEC[v][31:0]);
      end

      // R3 timer 0: reload 10, divide by 3, then freeze
      wr(1, 10); wr(2, 2); wr(0, 32'h01);
      idle(6);
      rd(3, rv); chk("R3 count after two steps", rv, 8);
      wr(0, 32'h00);
      idle(5);
      rd(3, rv); chk("R3 count frozen", rv, 8);

      // R4 timer 2 one-shot: N=3 P=1, expiry 6 cycles after load
      wr(9, 3); wr(10, 1); wr(8, 32'h15);
      idle(5);
      chk("R4 no irq before expiry", 32'(irq_req[2]), 0);
      idle(1);
      chk("R4 irq at expiry", 32'(irq_req[2]), 1);
      rd(11, rv); chk("R4 count zero", rv, 0);
      idle(4);
      rd(11, rv); chk("R4 count stays zero", rv, 0);
      wr(8, 0); wr(PEND_A, 32'h3F);

      // R5 timer 3 periodic: N=2 P=0, level 3
      wr(13, 2); wr(14, 0); wr(12, 32'h37);
      idle(1);
      chk("R5 no irq at first step", 32'(irq_req[3]), 0);
      idle(1);
      chk("R5 irq first period", 32'(irq_req[3]), 1);
      chk("R7 level field t3", 32'(irq_level[11:9]), 3);
      wr(PEND_A, 32'h08);
      chk("R6 w1c clears", 32'(irq_req[3]), 0);
      idle(1);
      chk("R5 irq second period", 32'(irq_req[3]), 1);
      rd(15, rv); chk("R5 count reloaded", rv, 2);
      wr(PEND_A, 32'h08);
      chk("R6 clear on quiet edge", 32'(irq_req[3]), 0);
      wr(PEND_A, 32'h08);
      chk("R6 expiry wins over clear", 32'(irq_req[3]), 1);
      wr(PEND_A, 32'h00);
      chk("R6 zero write ignored", 32'(irq_req[3]), 1);
      wr(12, 0); wr(PEND_A, 32'h3F);

      // R10 timer 1 with reload zero
      wr(5, 0); wr(4, 32'h17);
      idle(10);
      chk("R10 no irq", 32'(irq_req[1]), 0);
      rd(PEND_A, rv); chk("R10 no pending", rv & 32'h2, 0);
      rd(7, rv); chk("R10 count zero", rv, 0);
      wr(4, 0);

      // R7 timer 4 gating by enable and level
      wr(17, 1); wr(18, 0); wr(16, 32'h51);
      idle(1);
      rd(PEND_A, rv); chk("R7 pending set", (rv >> 4) & 1, 1);
      chk("R7 ie=0 holds irq low", 32'(irq_req[4]), 0);
      chk("R7 level field t4", 32'(irq_level[14:12]), 5);
      wr(16, 0); wr(PEND_A, 32'h10); wr(16, 32'h05);
      idle(1);
      chk("R7 level 0 holds irq low", 32'(irq_req[4]), 0);
      wr(16, 32'h55);
      chk("R7 irq with ie and level", 32'(irq_req[4]), 1);
      wr(16, 0); wr(PEND_A, 32'h3F);

      // R8 watchdog: N=4 P=1, retrigger two steps early
      wr(21, 4); wr(22, 1); wr(20, 32'h75);
      idle(5);
      wr(KICK_A, 32'h0);
      rd(23, rv); chk("R8 kick reloads count", rv, 4);
      idle(7);
      chk("R8 no fail before interval", 32'(sys_fail), 0);
      idle(1);
      chk("R8 fail at expiry", 32'(sys_fail), 1);
      chk("R7 watchdog irq", 32'(irq_req[5]), 1);

      // R9 latch behaviour
      idle(10);
      chk("R9 fail held", 32'(sys_fail), 1);
      wr(FAIL_A, 32'h0);
      chk("R9 bit0 clear ignored", 32'(sys_fail), 1);
      rd(FAIL_A, rv); chk("R9 status read", rv, 1);
      wr(FAIL_A, 32'h1);
      chk("R9 cleared", 32'(sys_fail), 0);

      // R1 reset clears a set latch
      wr(KICK_A, 32'h0);
      idle(9);
      chk("R8 refire after kick", 32'(sys_fail), 1);
      rst_n = 1'b0;
      #1;
      chk("R1 reset clears fail", 32'(sys_fail), 0);
      chk("R1 reset clears irq", 32'(irq_req), 0);
      idle(1);
      rst_n = 1'b1;
      rd(20, rv); chk("R1 ctrl cleared", rv, 0);
      rd(21, rv); chk("R1 reload cleared", rv, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule